// File: doc/BRIEF.md
# Programmable Internal Clock Selector

This block turns a set of reference ticks into the clock enables of a microcontroller-style clock tree. All logic runs in one synchronous domain: the inputs are single-cycle tick strobes and the outputs are single-cycle enable pulses, so nothing is gated and no clock is derived. Four references are available. The first is a fast tick that stands for an 8 MHz internal oscillator. The second is an independent low-rate tick of roughly 31 kHz. The third and fourth are a primary-oscillator tick and a secondary (timer) oscillator tick.

A 3-bit rate code picks the internal rate. The top code passes the fast tick through unchanged. Each lower code halves the rate. The lowest code switches to a 31 kHz path, and a tune bit sets where that path comes from: the independent slow tick, or the fast tick divided by 256. A 2-bit source field then chooses the system enable from the primary source, the secondary source or the internal path. A power-managed request stops the CPU enable. The peripheral enable also stops, unless the idle bit is set. A separate watchdog enable always follows the independent slow tick.

Top module: `clk_tree_sel`

## Requirements
- R1: Rate codes 3'b111 down to 3'b001 with source internal give one enable every 2^(7-code) fast ticks: 1, 2, 4, 8, 16, 32 and 64.
- R2: Rate code 3'b000 with tune_i=0 and source internal gives one enable per slow_tick_i.
- R3: Rate code 3'b000 with tune_i=1 and source internal gives one enable every 256 fast ticks.
- R4: wdt_en_o pulses one cycle after every slow_tick_i. It is unaffected by rate code, tune bit, source field and power-managed state.
- R5: Source field encoding is as follows: 2'b00 is primary, 2'b01 is secondary, and 2'b10 or 2'b11 is internal. The chosen tick reaches cpu_en_o and per_en_o one cycle later.
- R6: While pm_i=1 and idle_en_i=0, both cpu_en_o and per_en_o stay low.
- R7: While pm_i=1 and idle_en_i=1, cpu_en_o stays low and per_en_o keeps pulsing at the selected rate. The secondary source keeps running in this state. cpu_en_o is never high without per_en_o.
- R8: A changed rate, tune or source value is applied only in a cycle that produces an enable under the old setting. The divider restarts from zero at that point. The interval that contains the change therefore keeps its old length, and no short pulse occurs.
- R9: rst_ni low clears all three outputs and the divider. After reset the applied setting is the primary source with rate code 3'b000 and tune 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_tick_i | input | 1 | Fast internal reference tick (8 MHz) |
| slow_tick_i | input | 1 | Independent slow internal tick (31 kHz) |
| pri_tick_i | input | 1 | Primary oscillator tick |
| sec_tick_i | input | 1 | Secondary oscillator tick |
| freq_sel_i | input | 3 | Internal rate code |
| tune_i | input | 1 | Origin of the 31 kHz path: 0 slow tick, 1 fast/256 |
| src_sel_i | input | 2 | System source field |
| pm_i | input | 1 | Power-managed request |
| idle_en_i | input | 1 | Idle bit: keep peripherals running while power-managed |
| cpu_en_o | output | 1 | CPU clock enable |
| per_en_o | output | 1 | Peripheral clock enable |
| wdt_en_o | output | 1 | Watchdog low-rate enable |

## Verification
Two events can fall in the same cycle: a setting change and the enable pulse that acts as its boundary. The bench changes the rate code in the middle of an 8-tick interval. It checks that the pending interval still ends after 8 ticks and that the interval after it already has the new length of one tick. The second case is a power-managed request that arrives together with an enable pulse. That case is judged by counting enables over a fixed window while the request is held, with and without the idle bit.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  parameter int FREQ_W   = 3;
  parameter int SLOW_DIV = 256;
  localparam int CNT_W    = $clog2(SLOW_DIV);
  localparam int FREQ_MAX = (1 << FREQ_W) - 1;

  typedef enum logic [1:0] {
    SRC_PRI = 2'b00,
    SRC_SEC = 2'b01,
    SRC_INT = 2'b10
  } src_e;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic              tune;
    logic [1:0]        src;
  } sel_cfg_t;
endpackage

// File: rtl/clk_div.sv
module clk_div #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = fast_tick_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (fast_tick_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // limit only moves together with clr_i, so the count stays inside the window
  assert_cnt_in_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);
  assert_clr_restarts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
  import clk_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              pri_tick_i,
  input  logic              sec_tick_i,
  input  logic              div_tick_i,
  input  sel_cfg_t          cfg_i,
  output logic [CNT_W-1:0]  limit_o,
  output logic              clr_o,
  output logic              sel_tick_o
);
  sel_cfg_t cfg_q;
  logic     int_tick;
  logic     use_slow;

  assign use_slow = (cfg_q.freq == '0) && !cfg_q.tune;
  assign int_tick = use_slow ? slow_tick_i : div_tick_i;

  always_comb begin
    if (cfg_q.freq == '0)
      limit_o = CNT_W'(SLOW_DIV - 1);
    else
      limit_o = CNT_W'((32'd1 << (FREQ_MAX - 32'(cfg_q.freq))) - 32'd1);
  end

  always_comb begin
    unique casez (cfg_q.src)
      2'b00:   sel_tick_o = pri_tick_i;
      2'b01:   sel_tick_o = sec_tick_i;
      default: sel_tick_o = int_tick;
    endcase
  end

  // new setting lands only on an enable boundary of the old one
  assign clr_o = sel_tick_o && (cfg_i != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '{freq: '0, tune: 1'b0, src: SRC_PRI};
    else if (clr_o) cfg_q <= cfg_i;
  end

  assert_cfg_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_tick_o |=> $stable(cfg_q));
  assert_cfg_tracks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> (cfg_q == $past(cfg_i)));
endmodule

// File: rtl/clk_pm_gate.sv
module clk_pm_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_tick_i,
  input  logic slow_tick_i,
  input  logic pm_i,
  input  logic idle_en_i,
  output logic cpu_en_o,
  output logic per_en_o,
  output logic wdt_en_o
);
  logic cpu_run, per_run;

  assign cpu_run = !pm_i;
  assign per_run = !pm_i || idle_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_en_o <= 1'b0;
      per_en_o <= 1'b0;
      wdt_en_o <= 1'b0;
    end else begin
      cpu_en_o <= sel_tick_i && cpu_run;
      per_en_o <= sel_tick_i && per_run;
      wdt_en_o <= slow_tick_i;
    end
  end

  assert_sleep_stops_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_i && !idle_en_i) |=> (!cpu_en_o && !per_en_o));
  assert_idle_stops_cpu_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_i |=> !cpu_en_o);
  assert_idle_keeps_per_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_i && idle_en_i && sel_tick_i) |=> per_en_o);
  assert_wdt_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_tick_i |=> wdt_en_o);
  assert_wdt_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slow_tick_i |=> !wdt_en_o);
endmodule

// File: rtl/clk_tree_sel.sv
module clk_tree_sel
  import clk_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              pri_tick_i,
  input  logic              sec_tick_i,
  input  logic [FREQ_W-1:0] freq_sel_i,
  input  logic              tune_i,
  input  logic [1:0]        src_sel_i,
  input  logic              pm_i,
  input  logic              idle_en_i,
  output logic              cpu_en_o,
  output logic              per_en_o,
  output logic              wdt_en_o
);
  sel_cfg_t         cfg;
  logic [CNT_W-1:0] limit;
  logic             clr, div_tick, sel_tick;

  assign cfg = '{freq: freq_sel_i, tune: tune_i, src: src_sel_i};

  clk_div #(.CNT_W(CNT_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fast_tick_i (fast_tick_i),
    .clr_i       (clr),
    .limit_i     (limit),
    .tick_o      (div_tick)
  );

  clk_src_sel u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slow_tick_i (slow_tick_i),
    .pri_tick_i  (pri_tick_i),
    .sec_tick_i  (sec_tick_i),
    .div_tick_i  (div_tick),
    .cfg_i       (cfg),
    .limit_o     (limit),
    .clr_o       (clr),
    .sel_tick_o  (sel_tick)
  );

  clk_pm_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_tick_i  (sel_tick),
    .slow_tick_i (slow_tick_i),
    .pm_i        (pm_i),
    .idle_en_i   (idle_en_i),
    .cpu_en_o    (cpu_en_o),
    .per_en_o    (per_en_o),
    .wdt_en_o    (wdt_en_o)
  );

  assert_cpu_implies_per_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |-> per_en_o);
endmodule

// File: tb/sim_clk_tree_sel.sv
module sim_clk_tree_sel;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fast_tick = 1'b0, slow_tick = 1'b0, pri_tick = 1'b0, sec_tick = 1'b0;
  logic [2:0] freq_sel = 3'b000;
  logic       tune = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic       pm = 1'b0, idle_en = 1'b0;
  logic       cpu_en, per_en, wdt_en;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam int SLOW_P = 20, PRI_P = 3, SEC_P = 5;

  always #5 clk = ~clk;

  clk_tree_sel u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fast_tick_i(fast_tick), .slow_tick_i(slow_tick),
    .pri_tick_i(pri_tick), .sec_tick_i(sec_tick), .freq_sel_i(freq_sel), .tune_i(tune),
    .src_sel_i(src_sel), .pm_i(pm), .idle_en_i(idle_en),
    .cpu_en_o(cpu_en), .per_en_o(per_en), .wdt_en_o(wdt_en)
  );

  // free-running reference ticks, driven away from the active edge
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      fast_tick = 1'b1;
      slow_tick = (c % SLOW_P) == 0;
      pri_tick  = (c % PRI_P) == 0;
      sec_tick  = (c % SEC_P) == 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input bit use_per);
    return use_per ? per_en : cpu_en;
  endfunction

  task automatic wait_pulse(input bit use_per);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (pick(use_per)) return;
    end
  endtask

  task automatic gap(input bit use_per, output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (pick(use_per)) return;
    end
  endtask

  task automatic period(input bit use_per, output int n);
    wait_pulse(use_per);
    gap(use_per, n);
    gap(use_per, n);
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic [2:0] f, input logic t);
    @(negedge clk);
    src_sel = s; freq_sel = f; tune = t;
  endtask

  task automatic count_win(input int cyc, output int nc, output int np, output int nw);
    nc = 0; np = 0; nw = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      nc += cpu_en; np += per_en; nw += wdt_en;
    end
  endtask

  task automatic t_reset;
    int n;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 cpu_en in reset", cpu_en, 0);
      check("R9 wdt_en in reset", wdt_en, 0);
    end
    rst_ni = 1'b1;
    period(1'b0, n);
    check("R9 default primary period", n, PRI_P);
  endtask

  task automatic t_rates;
    int n;
    for (int code = 7; code >= 1; code--) begin
      set_cfg(2'b10, 3'(code), 1'b0);
      period(1'b0, n);
      period(1'b0, n);
      check($sformatf("R1 rate code %0d", code), n, 1 << (7 - code));
    end
  endtask

  task automatic t_slow;
    int n, nc, np, nw;
    set_cfg(2'b11, 3'b000, 1'b0);
    period(1'b0, n);
    check("R2 code 000 tune 0 period", n, SLOW_P);
    set_cfg(2'b10, 3'b000, 1'b1);
    period(1'b0, n);
    period(1'b0, n);
    check("R3 code 000 tune 1 period", n, 256);
    count_win(SLOW_P * 5, nc, np, nw);
    check("R4 wdt count with fast/256", nw, 5);
  endtask

  task automatic t_sources;
    int n;
    set_cfg(2'b01, 3'b101, 1'b0);
    period(1'b0, n);
    period(1'b0, n);
    check("R5 secondary period", n, SEC_P);
    set_cfg(2'b00, 3'b101, 1'b0);
    period(1'b0, n);
    period(1'b0, n);
    check("R5 primary period", n, PRI_P);
    set_cfg(2'b11, 3'b101, 1'b0);
    period(1'b0, n);
    period(1'b0, n);
    check("R5 internal via 11 period", n, 4);
  endtask

  task automatic t_power;
    int n, nc, np, nw;
    set_cfg(2'b00, 3'b111, 1'b0);
    period(1'b0, n);
    @(negedge clk); pm = 1'b1; idle_en = 1'b0;
    count_win(SLOW_P * 3, nc, np, nw);
    check("R6 sleep cpu count", nc, 0);
    check("R6 sleep per count", np, 0);
    check("R4 wdt during sleep", nw, 3);
    @(negedge clk); idle_en = 1'b1;
    count_win(PRI_P * 10, nc, np, nw);
    check("R7 idle cpu count", nc, 0);
    check("R7 idle per count", np, 10);
    set_cfg(2'b01, 3'b111, 1'b0);
    period(1'b1, n);
    period(1'b1, n);
    check("R7 secondary in idle period", n, SEC_P);
    @(negedge clk); pm = 1'b0; idle_en = 1'b0;
    period(1'b0, n);
    check("R7 cpu resumes", n, SEC_P);
  endtask

  task automatic t_switch;
    int n;
    set_cfg(2'b10, 3'b100, 1'b0);
    period(1'b0, n);
    period(1'b0, n);
    check("R8 pre-switch period", n, 8);
    wait_pulse(1'b0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    freq_sel = 3'b111;
    gap(1'b0, n);
    check("R8 interval holding change", n, 5);
    gap(1'b0, n);
    check("R8 first new interval", n, 1);
    // slow-going change: 1 -> 64
    wait_pulse(1'b0);
    freq_sel = 3'b001;
    gap(1'b0, n);
    check("R8 old rate finishes", n, 1);
    gap(1'b0, n);
    check("R8 counter restarted", n, 64);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rates();
    t_slow();
    t_sources();
    t_power();
    t_switch();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule